// File: doc/BRIEF.md
# Selectable Four-Decade Frequency Divider

The block divides a single input clock by 10, 100, 1,000 or 10,000 and drives the result as a symmetric square wave. Internally it is a chain of four divide-by-ten stages. Each stage is a modulo-5 counter that toggles a half-period flop, so every stage output has exactly 50% duty cycle. Stage k+1 is advanced by a single-cycle enable that stage k raises once per period, so the whole chain runs in one clock domain.

A 2-bit select code picks which of the four stage outputs reaches the output pin. The select code is registered on the falling clock edge. A change of ratio therefore takes effect one edge later and does not disturb the running counts. An active-high reset clears every stage at once and forces the output low.

Top module: `decade_divider`

## Requirements
- R1: All stage state, the registered select and hence `div_out` change only on a falling edge of `clk_in` (or asynchronously on reset assertion).
- R2: While `rst` is high, every stage is cleared and `div_out` is 0. Assertion acts immediately, without waiting for a clock edge.
- R3: With a constant select, `div_out` has a period of exactly N falling edges and is high for exactly N/2 of them.
- R4: The ratio N is set by `ratio_sel` (bit 1 is the upper select input): 2'b00 gives 10000, 2'b01 gives 1000, 2'b10 gives 100 and 2'b11 gives 10.
- R5: The chain has four decade stages. Each counts 0..4 and toggles its half-period flop on wrapping from 4, and advances only when the previous stage wraps while its own output is high.
- R6: After reset is released, `div_out` stays low and first rises on the N/2-th falling edge.
- R7: A change on `ratio_sel` takes effect on the next falling edge without clearing any stage. The output then follows the newly selected stage, whose phase continues from the count accumulated since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; the design advances on its falling edge |
| rst | input | 1 | Active-high asynchronous clear |
| ratio_sel | input | 2 | Division ratio code, mapping given in R4 |
| div_out | output | 1 | Divided square-wave output |

## Verification
The bench drives the select code through all four values without resetting. A design that cleared stages on a select change, or that mapped the codes backwards, diverges from the edge-count model within one period. It measures high time and period separately, which exposes a stage built as a one-cycle pulse or with a 4/6 split. A mid-count reset followed by a count of edges to the first rise catches a design that keeps partial counts or releases with the output high. Because the design is compared on every clock, outputs that move on the rising edge or one edge late are also caught.

// File: rtl/decade_divider.sv
module decade_divider #(
  parameter int STAGES = 4,
  parameter int BASE   = 5
) (
  input  logic       clk_in,
  input  logic       rst,
  input  logic [1:0] ratio_sel,
  output logic       div_out
);
  localparam int CW = $clog2(BASE);
  localparam logic [CW-1:0] LAST = CW'(BASE - 1);

  logic [CW-1:0] fives  [STAGES];
  logic          halves [STAGES];
  logic          step   [STAGES];
  logic [1:0]    tap;

  assign step[0] = 1'b1;

  for (genvar k = 0; k < STAGES - 1; k++) begin : g_carry
    assign step[k+1] = step[k] && (fives[k] == LAST) && halves[k];
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(negedge clk_in or posedge rst) begin
      if (rst) begin
        fives[k]  <= '0;
        halves[k] <= 1'b0;
      end else if (step[k]) begin
        if (fives[k] == LAST) begin
          fives[k]  <= '0;
          halves[k] <= ~halves[k];
        end else begin
          fives[k] <= fives[k] + 1'b1;
        end
      end
    end
  end

  always_ff @(negedge clk_in or posedge rst) begin
    if (rst) tap <= 2'd3;
    else     tap <= ~ratio_sel;
  end

  assign div_out = halves[tap];
endmodule

// File: rtl/decade_divider_chk.sv
module decade_divider_chk #(
  parameter int STAGES = 4,
  parameter int CW     = 3
) (
  input logic          clk_in,
  input logic          rst,
  input logic          div_out,
  input logic [CW-1:0] fives  [STAGES],
  input logic          halves [STAGES]
);
  a_r2_reset_clears: assert property (@(posedge clk_in) rst |-> !div_out)
    else $error("reset does not clear output");

  for (genvar k = 0; k < STAGES; k++) begin : g_rng
    a_r5_digit_range: assert property (@(negedge clk_in) disable iff (rst)
      fives[k] < CW'(5))
      else $error("stage digit out of range");

    a_r3_toggle_on_wrap: assert property (@(negedge clk_in) disable iff (rst)
      (!$past(rst) && (halves[k] != $past(halves[k]))) |-> ($past(fives[k]) == CW'(4) && fives[k] == '0))
      else $error("half flop toggled without a wrap");
  end

  for (genvar k = 0; k < STAGES - 1; k++) begin : g_cas
    a_r5_cascade_step: assert property (@(negedge clk_in) disable iff (rst)
      (!$past(rst) && (fives[k+1] != $past(fives[k+1]))) |-> ($past(fives[k]) == CW'(4) && $past(halves[k])))
      else $error("stage advanced without carry");
  end
endmodule

bind decade_divider decade_divider_chk #(.STAGES(STAGES), .CW(CW)) u_chk (
  .clk_in(clk_in), .rst(rst), .div_out(div_out), .fives(fives), .halves(halves)
);

// File: tb/sim_decade_divider.sv
module sim_decade_divider;
  logic clk_in = 1'b1;
  logic rst = 1'b1;
  logic [1:0] ratio_sel = 2'b11;
  logic div_out;
  int checks = 0, errors = 0, cyc = 0;
  int mcnt = 0;
  logic [1:0] msel = 2'b00;

  decade_divider u0 (.clk_in(clk_in), .rst(rst), .ratio_sel(ratio_sel), .div_out(div_out));

  always #5 clk_in = ~clk_in;

  function automatic int ratio(input logic [1:0] c);
    case (c)
      2'b00: return 10000;
      2'b01: return 1000;
      2'b10: return 100;
      default: return 10;
    endcase
  endfunction

  always @(negedge clk_in or posedge rst) begin
    if (rst) begin mcnt <= 0; msel <= 2'b00; end
    else begin mcnt <= mcnt + 1; msel <= ratio_sel; end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk_in) begin
    cyc <= cyc + 1;
    if (!rst) begin
      int n;
      n = ratio(msel);
      check("R1/R4/R7 per-cycle output", int'(div_out), int'((mcnt % n) >= n / 2));
    end
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_level(input logic v);
    do @(posedge clk_in); while (div_out !== v);
  endtask

  task automatic measure(input logic [1:0] code);
    int n, t0, t1, t2;
    n = ratio(code);
    wait_level(1'b0); wait_level(1'b1);
    t0 = cyc; wait_level(1'b0);
    t1 = cyc; wait_level(1'b1);
    t2 = cyc;
    check("R3 high time", t1 - t0, n / 2);
    check("R3 period", t2 - t0, n);
  endtask

  initial begin
    repeat (3) @(posedge clk_in);
    #1;
    check("R2 output low in reset", int'(div_out), 0);
    rst = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      @(posedge clk_in); #1;
      ratio_sel = 2'(i);
      measure(2'(i));
    end
    // R6: first rise after N/2 edges from a mid-count reset, ratio 100
    @(posedge clk_in); #1;
    ratio_sel = 2'b10;
    repeat (37) @(posedge clk_in);
    #1; rst = 1'b1;
    #1; check("R2 async clear mid count", int'(div_out), 0);
    repeat (2) @(posedge clk_in);
    #1; check("R2 held low", int'(div_out), 0);
    rst = 1'b0;
    begin
      int k;
      k = 0;
      do begin @(posedge clk_in); k++; end while (div_out !== 1'b1 && k < 200);
      check("R6 edges to first rise", k, 50);
    end
    measure(2'b10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule